// File: doc/BRIEF.md
# UART register and interrupt block

This block is the host-facing side of a UART. It holds a control register whose fields configure the serial engines, and it keeps a status register made up of sticky event flags and live FIFO and line state. It owns the transmit and receive FIFOs. Host writes to the transmit data word fill the transmit FIFO, and the transmit engine drains it. The receive engine fills the receive FIFO, and host reads of the receive data word drain it. A single active-high interrupt line combines the two pending flags with their enables.

The host uses a simple word-addressed bus. Read data comes back registered, one cycle after the request. The serializer and deserializer sit outside this block. They see the control word on `cfg_o` and talk to the FIFOs through push and pop strobes. When hardware flow control is on, the block holds back the transmit engine while CTS is low, and it drops RTS while the receive FIFO is full.

Top module: `uart_regblk`

## Requirements
- R1: Word offsets are decoded from `bus_addr[ADDR_W-1:2]`: 0 is control, 1 is receive data, 2 is transmit data and 3 is status. Control bits 20:0 are writable and read back as written, and its upper bits read 0. A read of the transmit data word returns 0.
- R2: A read of the receive data word returns the oldest received byte and removes it. A read while the receive FIFO is empty returns 0 and removes nothing. A push and a read in the same cycle are both honoured.
- R3: A write to the transmit data word appends `bus_wdata[7:0]` to the transmit FIFO. When the FIFO is full, the write is dropped and status bit 3 (transmit error) is set.
- R4: A receive push into a full receive FIFO is dropped and sets status bit 2 (overrun). Bytes already stored are kept.
- R5: A cycle with `rx_err_i` high sets status bit 4 (receive status error).
- R6: Status bits 4:0 clear when a 1 is written to the bit's position in the status word. Writing 0 leaves a bit unchanged. If a bit's set condition holds in the same cycle as its clear, the bit ends up set.
- R7: Status bit 0 (receive pending) is set in every cycle that the receive FIFO holds data. Status bit 1 (transmit pending) is set in every cycle that the transmit FIFO has a free entry. Both bits stay set until cleared.
- R8: The status word reports live state: bit 5 is receive FIFO empty, bit 6 is transmit FIFO full, bit 7 is `cts_i`, bit 8 is `rts_o`, bit 10 is transmit FIFO empty and bit 17 is `tx_busy_i`. Bits 9 and 31:18 read 0.
- R9: Status bits 16:11 hold the transmit FIFO entry count when control bit 14 is 1, and the receive FIFO entry count when it is 0.
- R10: `irq_o` is high exactly when control bit 15 (enable) is 1 and either status bit 0 and control bit 18 are both 1, or status bit 1 and control bit 19 are both 1.
- R11: `tx_ready_o` is high when the transmit FIFO holds data, control bit 15 is 1, and either control bit 12 (flow control) is 0 or `cts_i` is 1. `tx_data_o` shows the oldest entry. `tx_pop_i` removes that entry only while `tx_ready_o` is high.
- R12: `rts_o` is low only when control bit 12 is 1 and the receive FIFO is full.
- R13: After a reset, the control word is 0, both FIFOs are empty, flags 4:0 are 0 until the first clock, `bus_rdata` is 0 and `irq_o` is 0.
- R14: `bus_rdata` carries the value of the word addressed by a read request in the cycle after that request. It reflects the state before that cycle's updates, and it is 0 after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cfg_o | output | 21 | Control word for the serial engines |
| tx_ready_o | output | 1 | Transmit byte available to the engine |
| tx_data_o | output | DATA_W | Oldest transmit byte |
| tx_pop_i | input | 1 | Transmit engine takes the byte |
| tx_busy_i | input | 1 | Transmit shifter active |
| rx_push_i | input | 1 | Receive engine delivers a byte |
| rx_data_i | input | DATA_W | Received byte |
| rx_err_i | input | 1 | Receive status error event |
| cts_i | input | 1 | Clear-to-send line |
| rts_o | output | 1 | Request-to-send line |
| irq_o | output | 1 | Active-high interrupt |

## Verification
Two pairs of events can fall in the same cycle. In the first, a flag's own set condition coincides with a host write that clears it. In the second, a receive FIFO push coincides with a host read of the receive data word. The bench provokes the first pair by writing the clear bit of the receive pending flag while the receive FIFO is not empty, and by clearing overrun in the same cycle as another push into a full FIFO. It provokes the second by pushing a byte in the cycle that reads the last stored byte. A behavioural model built on queues predicts both results: the flag stays set, the read returns the older byte, and the new byte is read next. The model is compared against every output on every clock.

// File: rtl/uart_regblk_pkg.sv
package uart_regblk_pkg;
  // word offsets (address bits above the byte lane)
  localparam int OFF_CTRL = 0;
  localparam int OFF_RXD  = 1;
  localparam int OFF_TXD  = 2;
  localparam int OFF_STAT = 3;

  // control word
  localparam int CTRL_W    = 21;
  localparam int CB_AFE    = 12;
  localparam int CB_LVLSEL = 14;
  localparam int CB_EN     = 15;
  localparam int CB_RXIE   = 18;
  localparam int CB_TXIE   = 19;

  // status word
  localparam int NFLAG     = 5;
  localparam int SB_RXP    = 0;
  localparam int SB_TXP    = 1;
  localparam int SB_OVR    = 2;
  localparam int SB_TXERR  = 3;
  localparam int SB_RXERR  = 4;
  localparam int SB_RXEMP  = 5;
  localparam int SB_TXFUL  = 6;
  localparam int SB_CTS    = 7;
  localparam int SB_RTS    = 8;
  localparam int SB_TXEMP  = 10;
  localparam int SB_LVL    = 11;
  localparam int LVL_W     = 6;
  localparam int SB_BUSY   = 17;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/uart_rbfifo.sv
module uart_rbfifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/uart_w1c_flags.sv
module uart_w1c_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
  import uart_regblk_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 12,
  localparam int BUS_W   = 32,
  localparam int WORD_W  = ADDR_W - 2,
  localparam int TX_CW   = $clog2(TX_DEPTH + 1),
  localparam int RX_CW   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [CTRL_W-1:0] cfg_o,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_pop_i,
  input  logic              tx_busy_i,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_err_i,
  input  logic              cts_i,
  output logic              rts_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] word;
  logic hit_ctrl, hit_rxd, hit_txd, hit_stat;
  logic wr_ctrl, wr_txd, wr_stat, rd_any, rd_rxd;
  logic [CTRL_W-1:0] ctrl_q;
  logic [TX_CW-1:0]  tx_cnt;
  logic [RX_CW-1:0]  rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  flag_vec_t flag_set, flag_clr, flags_q;
  logic [LVL_W-1:0] lvl;
  logic [BUS_W-1:0] stat_w, rd_next;
  logic unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:CTRL_W]};

  // address decode
  assign word     = bus_addr[ADDR_W-1:2];
  assign hit_ctrl = bus_req && (word == WORD_W'(OFF_CTRL));
  assign hit_rxd  = bus_req && (word == WORD_W'(OFF_RXD));
  assign hit_txd  = bus_req && (word == WORD_W'(OFF_TXD));
  assign hit_stat = bus_req && (word == WORD_W'(OFF_STAT));
  assign wr_ctrl  = hit_ctrl && bus_we;
  assign wr_txd   = hit_txd && bus_we;
  assign wr_stat  = hit_stat && bus_we;
  assign rd_any   = bus_req && !bus_we;
  assign rd_rxd   = hit_rxd && !bus_we;

  // control register
  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end
  assign cfg_o = ctrl_q;

  // FIFOs
  uart_rbfifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_txf (
    .clk(clk), .rst(rst),
    .push(wr_txd), .wdata(bus_wdata[DATA_W-1:0]),
    .pop(tx_pop_i && tx_ready_o), .rdata(tx_data_o),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  uart_rbfifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxf (
    .clk(clk), .rst(rst),
    .push(rx_push_i), .wdata(rx_data_i),
    .pop(rd_rxd), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  // sticky event flags
  always_comb begin
    flag_set           = '0;
    flag_set[SB_RXP]   = !rx_empty;
    flag_set[SB_TXP]   = !tx_full;
    flag_set[SB_OVR]   = rx_push_i && rx_full;
    flag_set[SB_TXERR] = wr_txd && tx_full;
    flag_set[SB_RXERR] = rx_err_i;
    flag_clr           = wr_stat ? bus_wdata[NFLAG-1:0] : '0;
  end

  uart_w1c_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr), .q(flags_q)
  );

  // line and engine handshakes
  assign tx_ready_o = !tx_empty && ctrl_q[CB_EN] && (!ctrl_q[CB_AFE] || cts_i);
  assign rts_o      = !(ctrl_q[CB_AFE] && rx_full);
  assign irq_o      = ctrl_q[CB_EN] &&
                      ((flags_q[SB_RXP] && ctrl_q[CB_RXIE]) ||
                       (flags_q[SB_TXP] && ctrl_q[CB_TXIE]));

  // status word
  assign lvl = ctrl_q[CB_LVLSEL] ? LVL_W'(tx_cnt) : LVL_W'(rx_cnt);

  always_comb begin
    stat_w                  = '0;
    stat_w[NFLAG-1:0]       = flags_q;
    stat_w[SB_RXEMP]        = rx_empty;
    stat_w[SB_TXFUL]        = tx_full;
    stat_w[SB_CTS]          = cts_i;
    stat_w[SB_RTS]          = rts_o;
    stat_w[SB_TXEMP]        = tx_empty;
    stat_w[SB_LVL +: LVL_W] = lvl;
    stat_w[SB_BUSY]         = tx_busy_i;
  end

  // registered read path
  always_comb begin
    rd_next = '0;
    if (rd_any) begin
      if (hit_ctrl)                 rd_next = BUS_W'(ctrl_q);
      else if (hit_rxd && !rx_empty) rd_next = BUS_W'(rx_head);
      else if (hit_stat)            rd_next = stat_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/uart_regblk_chk.sv
module uart_regblk_chk
  import uart_regblk_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [WORD_W-1:0] word,
  input logic [CTRL_W-1:0] cfg,
  input logic              tx_ready_o,
  input logic              rts_o,
  input logic              irq_o,
  input logic              cts_i,
  input logic              rx_push_i,
  input logic              tx_full,
  input logic              rx_full,
  input logic              rx_empty,
  input logic [NFLAG-1:0]  flags,
  input logic [31:0]       bus_rdata
);
  a_r3_full_write_flags: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && word == WORD_W'(OFF_TXD) && tx_full) |=> flags[SB_TXERR]);

  a_r4_full_push_flags: assert property (@(posedge clk) disable iff (rst)
    (rx_push_i && rx_full) |=> flags[SB_OVR]);

  a_r11_cts_holds_tx: assert property (@(posedge clk) disable iff (rst)
    (cfg[CB_AFE] && !cts_i) |-> !tx_ready_o);

  a_r12_rts_free_without_afe: assert property (@(posedge clk) disable iff (rst)
    !cfg[CB_AFE] |-> rts_o);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> cfg[CB_EN]);

  a_r2_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && word == WORD_W'(OFF_RXD) && rx_empty) |=> (bus_rdata == 32'd0));

  a_r14_ctrl_readback: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && word == WORD_W'(OFF_CTRL)) |=> (bus_rdata == 32'($past(cfg))));
endmodule

bind uart_regblk uart_regblk_chk #(.WORD_W(ADDR_W - 2)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .word(word),
  .cfg(ctrl_q), .tx_ready_o(tx_ready_o), .rts_o(rts_o), .irq_o(irq_o),
  .cts_i(cts_i), .rx_push_i(rx_push_i), .tx_full(tx_full), .rx_full(rx_full),
  .rx_empty(rx_empty), .flags(flags_q), .bus_rdata(bus_rdata)
);

// File: tb/uart_regblk_test.sv
module uart_regblk_test;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 16;
  localparam int RXD = 16;
  localparam logic [11:0] A_CTRL = 12'h000, A_RXD = 12'h004, A_TXD = 12'h008, A_STAT = 12'h00C;
  localparam logic [31:0] C_BASE = 32'h000C_8000; // enable + both interrupt enables

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [20:0] cfg_o;
  logic tx_ready_o, tx_pop_i = 0, tx_busy_i = 0;
  logic [7:0] tx_data_o, rx_data_i = '0;
  logic rx_push_i = 0, rx_err_i = 0, cts_i = 1, rts_o, irq_o;

  int checks = 0, failures = 0;
  bit mon_on = 0;

  uart_regblk #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .DATA_W(8), .ADDR_W(12)) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_o(cfg_o),
    .tx_ready_o(tx_ready_o), .tx_data_o(tx_data_o), .tx_pop_i(tx_pop_i),
    .tx_busy_i(tx_busy_i), .rx_push_i(rx_push_i), .rx_data_i(rx_data_i),
    .rx_err_i(rx_err_i), .cts_i(cts_i), .rts_o(rts_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  logic [20:0] m_ctrl = '0;
  logic [4:0]  m_flags = '0;
  logic [31:0] m_rdata = '0;
  logic [4:0]  m_set, m_clr;
  logic [31:0] m_st;
  int          m_word;
  bit          m_txacc, m_rxacc, m_txpop, m_rxpop;

  function automatic bit m_rts();
    return !(m_ctrl[12] && rxq.size() == RXD);
  endfunction
  function automatic bit m_ready();
    return txq.size() > 0 && m_ctrl[15] && (!m_ctrl[12] || cts_i);
  endfunction
  function automatic bit m_irq();
    return m_ctrl[15] && ((m_flags[0] && m_ctrl[18]) || (m_flags[1] && m_ctrl[19]));
  endfunction
  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    int lv = m_ctrl[14] ? txq.size() : rxq.size();
    s[4:0]   = m_flags;
    s[5]     = rxq.size() == 0;
    s[6]     = txq.size() == TXD;
    s[7]     = cts_i;
    s[8]     = m_rts();
    s[10]    = txq.size() == 0;
    s[16:11] = lv[5:0];
    s[17]    = tx_busy_i;
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      txq.delete(); rxq.delete();
      m_ctrl = '0; m_flags = '0; m_rdata = '0;
    end else begin
      m_word = int'(bus_addr[11:2]);
      m_st = m_status();
      m_rdata = '0;
      if (bus_req && !bus_we) begin
        if (m_word == 0) m_rdata = 32'(m_ctrl);
        else if (m_word == 1 && rxq.size() > 0) m_rdata = 32'(rxq[0]);
        else if (m_word == 3) m_rdata = m_st;
      end
      m_txacc = bus_req && bus_we && m_word == 2 && txq.size() < TXD;
      m_txpop = tx_pop_i && m_ready();
      m_rxacc = rx_push_i && rxq.size() < RXD;
      m_rxpop = bus_req && !bus_we && m_word == 1 && rxq.size() > 0;
      m_set = {rx_err_i,
               bus_req && bus_we && m_word == 2 && txq.size() == TXD,
               rx_push_i && rxq.size() == RXD,
               txq.size() < TXD,
               rxq.size() > 0};
      m_clr = (bus_req && bus_we && m_word == 3) ? bus_wdata[4:0] : 5'd0;
      m_flags = (m_flags & ~m_clr) | m_set;
      if (bus_req && bus_we && m_word == 0) m_ctrl = bus_wdata[20:0];
      if (m_txpop) void'(txq.pop_front());
      if (m_txacc) txq.push_back(bus_wdata[7:0]);
      if (m_rxpop) void'(rxq.pop_front());
      if (m_rxacc) rxq.push_back(rx_data_i);
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // per-cycle comparison, a quarter period after the falling edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (mon_on) begin
      chk("R14 bus_rdata vs model", bus_rdata, m_rdata);
      chk("R10 irq_o vs model", 32'(irq_o), 32'(m_irq()));
      chk("R11 tx_ready_o vs model", 32'(tx_ready_o), 32'(m_ready()));
      chk("R12 rts_o vs model", 32'(rts_o), 32'(m_rts()));
      chk("R1 cfg_o vs model", 32'(cfg_o), 32'(m_ctrl));
      if (m_ready()) chk("R11 tx_data_o vs model", 32'(tx_data_o), 32'(txq[0]));
    end
  end

  // ---------------- bus and engine tasks ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask
  task automatic stat_bit(input int b, input logic e, input string tag);
    logic [31:0] v;
    rd(A_STAT, v);
    chk(tag, 32'(v[b]), 32'(e));
  endtask
  task automatic rx_put(input logic [7:0] d);
    rx_push_i = 1; rx_data_i = d;
    @(negedge clk);
    rx_push_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R13 watchdog got=hung exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R13 irq_o in reset", 32'(irq_o), 0);
    chk("R13 bus_rdata in reset", bus_rdata, 0);
    rst = 0;
    mon_on = 1;
    @(negedge clk);
    chk("R13 tx_ready_o after reset", 32'(tx_ready_o), 0);
    rd(A_CTRL, v);  chk("R13 control after reset", v, 0);
    rd(A_STAT, v);  chk("R13 R8 status after reset", v, 32'h0000_05A2);

    // control write and read-back
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v);  chk("R1 control upper bits zero", v, 32'h001F_FFFF);
    wr(A_CTRL, C_BASE);
    rd(A_CTRL, v);  chk("R1 control read-back", v, C_BASE);
    chk("R10 irq from tx pending", 32'(irq_o), 1);
    rd(A_TXD, v);   chk("R1 tx data word reads zero", v, 0);

    // fill the transmit FIFO, then one more write
    for (int i = 0; i < TXD; i++) wr(A_TXD, 32'hA0 + i);
    wr(A_TXD, 32'hEE);
    stat_bit(3, 1, "R3 tx error on full write");
    stat_bit(6, 1, "R8 tx full");
    stat_bit(10, 0, "R8 tx not empty");
    wr(A_CTRL, C_BASE | 32'h4000);
    rd(A_STAT, v);  chk("R9 tx level selected", 32'(v[16:11]), TXD);
    wr(A_CTRL, C_BASE);
    rd(A_STAT, v);  chk("R9 rx level selected", 32'(v[16:11]), 0);
    wr(A_STAT, 32'h2);
    stat_bit(1, 0, "R7 R6 tx pending stays clear while full");
    chk("R10 irq low with no pending", 32'(irq_o), 0);
    wr(A_STAT, 32'h0);
    stat_bit(3, 1, "R6 zero write keeps flag");
    wr(A_STAT, 32'h8);
    stat_bit(3, 0, "R6 tx error cleared");

    // flow control holds the engine off while CTS is low
    wr(A_CTRL, C_BASE | 32'h5000);
    cts_i = 0;
    @(negedge clk);
    chk("R11 not ready with cts low", 32'(tx_ready_o), 0);
    tx_pop_i = 1; @(negedge clk); tx_pop_i = 0;
    rd(A_STAT, v);  chk("R11 pop ignored when not ready", 32'(v[16:11]), TXD);
    stat_bit(7, 0, "R8 cts low seen");
    cts_i = 1;
    @(negedge clk);
    for (int i = 0; i < TXD; i++) begin
      chk("R11 tx order", 32'(tx_data_o), 32'hA0 + i);
      tx_pop_i = 1; @(negedge clk); tx_pop_i = 0;
    end
    chk("R11 not ready when empty", 32'(tx_ready_o), 0);
    stat_bit(10, 1, "R8 tx empty");
    wr(A_CTRL, C_BASE);
    tx_busy_i = 1;
    stat_bit(17, 1, "R8 busy reported");
    tx_busy_i = 0;

    // receive path, including push and read in one cycle
    rx_put(8'h31); rx_put(8'h32); rx_put(8'h33);
    rd(A_RXD, v);   chk("R2 oldest first", v, 32'h31);
    rd(A_RXD, v);   chk("R2 second", v, 32'h32);
    rx_push_i = 1; rx_data_i = 8'h34;
    rd(A_RXD, v);   chk("R2 read during push", v, 32'h33);
    rx_push_i = 0;
    rd(A_RXD, v);   chk("R2 pushed byte kept", v, 32'h34);
    rd(A_RXD, v);   chk("R2 empty read zero", v, 0);
    stat_bit(5, 1, "R8 rx empty");
    stat_bit(0, 1, "R7 rx pending sticky");
    wr(A_STAT, 32'h1);
    stat_bit(0, 0, "R6 rx pending cleared");
    rx_put(8'h55);
    wr(A_STAT, 32'h1);
    stat_bit(0, 1, "R6 set wins over clear");
    rd(A_RXD, v);   chk("R2 drain", v, 32'h55);

    // overrun with flow control on
    wr(A_CTRL, C_BASE | 32'h1000);
    for (int i = 0; i < RXD; i++) rx_put(8'h60 + i);
    chk("R12 rts low when rx full", 32'(rts_o), 0);
    stat_bit(8, 0, "R8 rts in status");
    rx_put(8'hFF);
    stat_bit(2, 1, "R4 overrun set");
    rx_push_i = 1; rx_data_i = 8'hFE;
    wr(A_STAT, 32'h4);
    rx_push_i = 0;
    stat_bit(2, 1, "R6 overrun set wins over clear");
    wr(A_STAT, 32'h4);
    stat_bit(2, 0, "R6 overrun cleared");
    rd(A_RXD, v);   chk("R4 stored bytes kept", v, 32'h60);
    chk("R12 rts back high", 32'(rts_o), 1);
    for (int i = 1; i < RXD; i++) begin
      rd(A_RXD, v); chk("R4 drain order", v, 32'h60 + i);
    end
    rd(A_RXD, v);   chk("R4 dropped byte absent", v, 0);

    // receive status error
    rx_err_i = 1; @(negedge clk); rx_err_i = 0;
    stat_bit(4, 1, "R5 rx error set");
    wr(A_STAT, 32'h10);
    stat_bit(4, 0, "R5 rx error cleared");

    // interrupt from the receive side only
    wr(A_CTRL, 32'h0004_8000);
    wr(A_STAT, 32'h1F);
    chk("R10 irq low, tx enable off", 32'(irq_o), 0);
    rx_put(8'h77);
    @(negedge clk);
    chk("R10 irq from rx pending", 32'(irq_o), 1);
    wr(A_CTRL, 32'h0004_0000);
    chk("R10 irq gated by enable", 32'(irq_o), 0);
    rd(A_RXD, v);   chk("R2 rx byte", v, 32'h77);

    // reset with data queued
    wr(A_CTRL, C_BASE);
    wr(A_TXD, 32'h12);
    rx_put(8'h34);
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    rd(A_STAT, v);  chk("R13 status after second reset", v, 32'h0000_05A2);
    rd(A_CTRL, v);  chk("R13 control after second reset", v, 0);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule